// File: doc/BRIEF.md
# Dual-Format Stereo Serial Audio Transmitter

This block serialises stereo pairs of 24-bit two's-complement samples onto one data line, one bit per serial clock, left word then right word in each frame. A frame is 64 serial-clock periods; the word clock marks which channel the current 32-period half belongs to. The serial and word clocks come in as inputs that are synchronous to the master clock `clk_i`. They may come from an on-chip divider or from external pins. The block finds their edges itself.

Two framings are supported: I²S, where word clock low marks the left channel and the MSB follows one serial clock after the word-clock edge, and left-justified, where word clock high marks the left channel and the MSB goes out on the serial clock right after the edge. The framing is not set by a register. After reset the data pin stays undriven for a short window while the block reads the level that an external pull resistor gives it. At the end of that window the level is latched and the pin becomes an output. Sample pairs are offered with a valid strobe at any time, but a pair only goes into use at the start of a frame. If no new pair has arrived, the previous one is sent again.

Top module: `audio_ser_tx`

## Requirements
- R1: Each half-frame sends one 24-bit word MSB first (bit 23 down to bit 0), and in each frame the left word goes out before the right word.
- R2: The pin level read at the end of the strap window picks the framing: high selects I²S, low selects left-justified.
- R3: In left-justified framing, word clock high marks the left channel, and the MSB is the bit sampled on the first serial-clock rising edge after the word-clock transition.
- R4: In I²S framing, word clock low marks the left channel, and the MSB is the bit sampled on the second serial-clock rising edge after the word-clock transition. The bit sampled on the first rising edge is 0.
- R5: Every bit of a 32-period half-frame that does not carry a word bit is sent as 0.
- R6: `sdo_oe_o` is low while reset is held and for 16 `clk_i` cycles after reset is released. It goes high on the 16th rising clock edge after release and stays high until the next reset.
- R7: `sdo_o` changes only on the first `clk_i` edge at which a serial-clock falling edge is seen, so it is stable around every serial-clock rising edge.
- R8: A pair offered with `smp_valid_i` is stored and goes into use only at the next frame start (the word-clock transition into the left half). A pair that arrives mid-frame does not change the frame in progress.
- R9: If no pair arrives before a frame start, the previous pair is sent again.
- R10: While `rst_ni` is low, `sdo_o` and `sdo_oe_o` stay 0 whatever the serial and word clocks do.
- R11: The latched framing does not change until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, idle when low |
| sclk_i | input | 1 | Serial bit clock, synchronous to clk_i |
| lrck_i | input | 1 | Word (channel) clock, synchronous to clk_i |
| smp_l_i | input | 24 | Left sample, two's complement |
| smp_r_i | input | 24 | Right sample, two's complement |
| smp_valid_i | input | 1 | Offers the left/right pair for storing |
| sdo_pad_i | input | 1 | Level read back from the data pin |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data pin |

## Verification
The bench builds the block with its default parameters: 24-bit words in 32-bit slots and a 16-cycle strap window. It drives a serial clock of two master-clock periods, so every bit position and the whole strap window are visible within a few hundred cycles. It resets the block once with the pin pulled low and once pulled high. In each framing it sends full-scale negative and positive extremes, a pair replaced in the middle of a frame, and a frame with no new pair. Every captured 64-bit frame is compared with a slot image that the bench builds on its own from the framing rules.

// File: rtl/audio_ser_tx_pkg.sv
package audio_ser_tx_pkg;
  typedef enum logic {
    FMT_LJ  = 1'b0,
    FMT_I2S = 1'b1
  } fmt_e;
endpackage

// File: rtl/strap_sampler.sv
module strap_sampler #(
  parameter int unsigned WIN = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pad_i,
  output logic                     done_o,
  output audio_ser_tx_pkg::fmt_e   fmt_o
);
  import audio_ser_tx_pkg::*;
  localparam int unsigned CW = (WIN > 1) ? $clog2(WIN) : 1;

  logic [CW-1:0] cnt_q;
  logic          done_q;
  fmt_e          fmt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      fmt_q  <= FMT_LJ;
    end else if (!done_q) begin
      if (cnt_q == CW'(WIN - 1)) begin
        done_q <= 1'b1;
        fmt_q  <= pad_i ? FMT_I2S : FMT_LJ;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign fmt_o  = fmt_q;

  // R11
  fmt_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> (done_q && $stable(fmt_q)));
endmodule

// File: rtl/frame_tracker.sv
module frame_tracker #(
  parameter int unsigned SLOT_W = 32,
  localparam int unsigned PW    = $clog2(SLOT_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   sclk_i,
  input  logic                   lrck_i,
  input  audio_ser_tx_pkg::fmt_e fmt_i,
  output logic                   fall_o,
  output logic                   start_o,
  output logic                   left_o,
  output logic [PW-1:0]          pos_o,
  output logic                   synced_o
);
  import audio_ser_tx_pkg::*;

  logic          sclk_q, lrck_last_q, synced_q;
  logic [PW-1:0] pos_q, pos_nxt;
  logic          fall, trans;

  assign fall  = sclk_q & ~sclk_i & en_i;
  assign trans = fall & (lrck_i != lrck_last_q);

  always_comb begin
    if (trans)                      pos_nxt = '0;
    else if (pos_q == PW'(SLOT_W))  pos_nxt = pos_q;
    else                            pos_nxt = pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      lrck_last_q <= 1'b0;
      synced_q    <= 1'b0;
      pos_q       <= PW'(SLOT_W);
    end else begin
      sclk_q <= sclk_i;
      if (sclk_q && !sclk_i) lrck_last_q <= lrck_i;
      if (fall) begin
        pos_q    <= pos_nxt;
        synced_q <= synced_q | trans;
      end
    end
  end

  assign fall_o   = fall;
  assign start_o  = trans;
  assign left_o   = (fmt_i == FMT_I2S) ? ~lrck_i : lrck_i;
  assign pos_o    = pos_nxt;
  assign synced_o = synced_q | trans;

  // R5
  pos_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= PW'(SLOT_W));
  // R6
  idle_until_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !synced_q);
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned SLOT_W = 32,
  localparam int unsigned PW    = $clog2(SLOT_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fall_i,
  input  logic                   start_i,
  input  logic                   left_i,
  input  logic [PW-1:0]          pos_i,
  input  logic                   synced_i,
  input  audio_ser_tx_pkg::fmt_e fmt_i,
  input  logic [WORD_W-1:0]      pend_l_i,
  input  logic [WORD_W-1:0]      pend_r_i,
  output logic                   sdo_o
);
  import audio_ser_tx_pkg::*;

  logic [WORD_W-1:0] act_l_q, act_r_q, word, shifted;
  logic [PW-1:0]     idx;
  logic              load, hit, bit_val, sdo_q;

  assign load = start_i & left_i;
  assign word = left_i ? (load ? pend_l_i : act_l_q) : act_r_q;

  // I2S delays the MSB by one slot position
  always_comb begin
    if (fmt_i == FMT_I2S) begin
      hit = (pos_i != '0) && (pos_i <= PW'(WORD_W));
      idx = pos_i - 1'b1;
    end else begin
      hit = (pos_i < PW'(WORD_W));
      idx = pos_i;
    end
    shifted = word << idx;
    bit_val = hit & shifted[WORD_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_l_q <= '0;
      act_r_q <= '0;
      sdo_q   <= 1'b0;
    end else if (fall_i) begin
      if (load) begin
        act_l_q <= pend_l_i;
        act_r_q <= pend_r_i;
      end
      sdo_q <= synced_i & bit_val;
    end
  end

  assign sdo_o = sdo_q;

  // R7
  sdo_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sdo_q));
  // R8
  pair_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> ($stable(act_l_q) && $stable(act_r_q)));
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
  parameter int unsigned WORD_W       = 24,
  parameter int unsigned SLOT_W       = 32,
  parameter int unsigned STRAP_CYCLES = 16,
  localparam int unsigned PW          = $clog2(SLOT_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              lrck_i,
  input  logic [WORD_W-1:0] smp_l_i,
  input  logic [WORD_W-1:0] smp_r_i,
  input  logic              smp_valid_i,
  input  logic              sdo_pad_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  import audio_ser_tx_pkg::*;

  logic              done, fall, start, left, synced;
  logic [PW-1:0]     pos;
  fmt_e              fmt;
  logic [WORD_W-1:0] pend_l_q, pend_r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
    end else if (smp_valid_i) begin
      pend_l_q <= smp_l_i;
      pend_r_q <= smp_r_i;
    end
  end

  strap_sampler #(.WIN(STRAP_CYCLES)) u_strap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (sdo_pad_i),
    .done_o (done),
    .fmt_o  (fmt)
  );

  frame_tracker #(.SLOT_W(SLOT_W)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (done),
    .sclk_i   (sclk_i),
    .lrck_i   (lrck_i),
    .fmt_i    (fmt),
    .fall_o   (fall),
    .start_o  (start),
    .left_o   (left),
    .pos_o    (pos),
    .synced_o (synced)
  );

  word_shifter #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall),
    .start_i  (start),
    .left_i   (left),
    .pos_i    (pos),
    .synced_i (synced),
    .fmt_i    (fmt),
    .pend_l_i (pend_l_q),
    .pend_r_i (pend_r_q),
    .sdo_o    (sdo_o)
  );

  assign sdo_oe_o = done;

  // R6
  oe_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |=> sdo_oe_o);
  // R10
  quiet_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);
endmodule

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, lrck = 1'b0, valid = 1'b0;
  logic [23:0] sl = '0, sr = '0;
  logic        strap = 1'b0;
  logic        sdo, oe, pad;
  int          n_run = 0, n_fail = 0;
  bit          i2s = 1'b0;
  bit          ended = 1'b0;

  always #4 clk = ~clk;

  assign pad = oe ? sdo : strap;

  audio_ser_tx u_audio_ser_tx (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .lrck_i(lrck),
    .smp_l_i(sl), .smp_r_i(sr), .smp_valid_i(valid),
    .sdo_pad_i(pad), .sdo_o(sdo), .sdo_oe_o(oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit f_i2s, input logic [23:0] l, input logic [23:0] r);
    logic [31:0] a, b;
    if (f_i2s) begin a = {1'b0, l, 7'b0}; b = {1'b0, r, 7'b0}; end
    else       begin a = {l, 8'b0};       b = {r, 8'b0};       end
    return {a, b};
  endfunction

  // R10 R6 R2: reset with clocks running, then strap window
  task automatic do_reset(input bit pull_high);
    strap = pull_high;
    @(negedge clk) rst_n = 1'b0; valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) sclk = ~sclk; lrck = (i > 3);
    end
    chk("R10 oe in reset", 64'(oe), 64'd0);
    chk("R10 sdo in reset", 64'(sdo), 64'd0);
    sclk = 1'b1;
    @(negedge clk) rst_n = 1'b1;
    repeat (15) @(posedge clk);
    #1 chk("R6 oe inside window", 64'(oe), 64'd0);
    @(posedge clk);
    #1 chk("R6 oe after window", 64'(oe), 64'd1);
    i2s = pull_high;
    lrck = i2s ? 1'b1 : 1'b0;  // right-channel level
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) sclk = 1'b0;
      @(negedge clk) sclk = 1'b1;
    end
  endtask

  task automatic load(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk) sl = l; sr = r; valid = 1'b1;
    @(negedge clk) valid = 1'b0;
  endtask

  // R1 R3 R4 R5 R7 R8 R9: one frame, bits captured at each serial-clock rise
  task automatic frame(input string req, input logic [23:0] el, input logic [23:0] er,
                       input bit mid, input logic [23:0] ml, input logic [23:0] mr);
    logic [63:0] cap = '0;
    logic        lv = i2s ? 1'b0 : 1'b1;
    for (int s = 0; s < 64; s++) begin
      @(negedge clk) sclk = 1'b0; lrck = (s < 32) ? lv : ~lv;
      if (mid && s == 10) begin sl = ml; sr = mr; valid = 1'b1; end
      if (s == 11) valid = 1'b0;
      @(negedge clk) cap = {cap[62:0], sdo}; sclk = 1'b1;
    end
    chk(req, cap, exp_frame(i2s, el, er));
  endtask

  initial begin
    // left-justified (pin pulled low): R2 R3
    do_reset(1'b0);
    load(24'h800000, 24'h7FFFFF);
    frame("R1 R3 R5 LJ extremes", 24'h800000, 24'h7FFFFF, 1'b0, '0, '0);
    load(24'h123456, 24'hABCDEF);
    frame("R8 LJ mid-frame pair ignored", 24'h123456, 24'hABCDEF, 1'b1, 24'h0F0F0F, 24'hF0F0F0);
    frame("R8 LJ mid pair used next frame", 24'h0F0F0F, 24'hF0F0F0, 1'b0, '0, '0);
    frame("R9 LJ repeat pair", 24'h0F0F0F, 24'hF0F0F0, 1'b0, '0, '0);
    // I2S (pin pulled high): R2 R4 R11
    do_reset(1'b1);
    load(24'h800001, 24'h7FFFFE);
    frame("R2 R4 R5 I2S extremes", 24'h800001, 24'h7FFFFE, 1'b0, '0, '0);
    load(24'hFFFFFF, 24'h000001);
    frame("R8 I2S mid-frame pair ignored", 24'hFFFFFF, 24'h000001, 1'b1, 24'hA5A5A5, 24'h5A5A5A);
    frame("R8 I2S mid pair used next frame", 24'hA5A5A5, 24'h5A5A5A, 1'b0, '0, '0);
    frame("R9 R11 I2S repeat pair", 24'hA5A5A5, 24'h5A5A5A, 1'b0, '0, '0);
    // reset again from an active stream
    do_reset(1'b0);
    load(24'h000000, 24'hC00003);
    frame("R1 R3 LJ after re-reset", 24'h000000, 24'hC00003, 1'b0, '0, '0);
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!ended) begin
      ended = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule